// File: doc/BRIEF.md
# Dual Event Counter Unit

This block is a performance-monitoring unit holding two 40-bit event counters. Each counter has its own event-select register that names the event code to count and how to qualify it. Each cycle the block receives a small set of event lanes, plus a flag telling whether the processor runs at kernel level. Every lane carries a valid bit, an event code, unit bits and an increment count. Software reaches the selects, the counters and a status word through a word-wide register port addressed by index. Read data is registered.

A select register picks matching lanes by event code and unit mask, and filters them by privilege level. It can turn the summed count into a threshold comparison, inverted or edge-triggered if needed. A single enable bit in counter 0's select register gates both counters. A 32-bit write to a counter is sign-extended to 40 bits. When a counter carries out of its top bit, it wraps and sets a sticky flag. If that counter's select allows it, the block also raises a one-cycle interrupt request. The request path then masks itself until software unmasks it.

Top module: `pmu_dual_ctr`

## Requirements
- R1: Register indices are 0 select 0, 1 select 1, 2 counter 0 bits 31:0, 3 counter 0 bits 39:32 (in read bits 7:0), 4 counter 1 bits 31:0, 5 counter 1 bits 39:32, 6 status. Read data appears on the cycle after the index is presented. After reset every register reads zero and the interrupt request is low.
- R2: Select layout: event code 7:0, unit mask 15:8, user enable 16, kernel enable 17, edge 18, interrupt enable 20, global enable 22, invert 23, threshold 31:24. Bits 19 and 21 always read zero.
- R3: A lane matches when it is valid, its code equals the select's event code, and either the unit mask is zero or the lane's unit bits share a set bit with it. With a zero threshold and edge off, a counter adds the sum of the counts of all matching lanes each cycle.
- R4: Counting is allowed with the user enable when the kernel flag is 0, and with the kernel enable when it is 1.
- R5: With a nonzero threshold, the counter adds one in each cycle where the qualified sum is at least the threshold. With invert set, it adds one when the sum is below the threshold.
- R6: With edge set, the counter adds one only on a cycle where the comparison is true and was false the cycle before.
- R7: Only bit 22 of select 0 enables counting, and it does so for both counters. Bit 22 of select 1 has no effect.
- R8: A select register holding zero leaves its counter unchanged.
- R9: A write to a counter's low index loads the 32 data bits and copies bit 31 into bits 39:32. Writes to a high index are ignored.
- R10: Event 0xC1 never counts on counter 1. Events 0x11, 0x12 and 0x13 never count on counter 0.
- R11: A carry out of bit 39 wraps the counter and sets that counter's sticky flag in status bit 0 (counter 0) or bit 1 (counter 1). Writing 1 to a flag bit clears it.
- R12: An overflow on a counter whose interrupt enable is set, while the request is unmasked, drives the interrupt request high for exactly one cycle and sets the mask (status bit 2). Further overflows raise no request until software writes 1 to status bit 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register index |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| ev_valid | input | NUM_LANES | Per-lane event valid |
| ev_code | input | 8*NUM_LANES | Per-lane event code |
| ev_unit | input | 8*NUM_LANES | Per-lane unit bits |
| ev_cnt | input | CNT_W*NUM_LANES | Per-lane increment count |
| priv_kernel | input | 1 | 1 when running at kernel level |
| irq_o | output | 1 | Overflow interrupt request pulse |

## Verification
The assertions assume that a register write never targets a counter in the same cycle as an overflow that software does not expect. They also assume that the event lanes hold legal values on every cycle, with no X on valid lanes. The stimulus changes lanes and register strobes only away from the active clock edge. It sets each select only while the lanes are idle, and it stops counting by zeroing the select on the last counted cycle. This gives every observation window an exact number of qualified cycles. Overflow is reached by loading a counter one below wrap, so the carry cycle is known in advance.

// File: rtl/pmu_pkg.sv
package pmu_pkg;
  localparam int NCTR     = 2;
  localparam int CTR_W    = 40;
  localparam int REG_W    = 32;
  localparam int ADDR_W   = 3;
  localparam int STAT_IDX = 6;

  typedef struct packed {
    logic [7:0] cmask;
    logic       inv;
    logic       en;
    logic       rsv21;
    logic       intr;
    logic       rsv19;
    logic       edg;
    logic       os;
    logic       usr;
    logic [7:0] umask;
    logic [7:0] evt;
  } pmu_sel_t;

  localparam logic [31:0] SEL_WMASK = 32'hFFD7_FFFF;
endpackage

// File: rtl/pmu_evt_filter.sv
module pmu_evt_filter
  import pmu_pkg::*;
#(
  parameter int CTR_IDX   = 0,
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 4,
  localparam int SUM_W    = $clog2(NUM_LANES * ((1 << CNT_W) - 1) + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  pmu_sel_t                   sel,
  input  logic                       global_en,
  input  logic [NUM_LANES-1:0]       ev_valid,
  input  logic [NUM_LANES*8-1:0]     ev_code,
  input  logic [NUM_LANES*8-1:0]     ev_unit,
  input  logic [NUM_LANES*CNT_W-1:0] ev_cnt,
  input  logic                       priv_kernel,
  output logic [SUM_W-1:0]           inc
);
  logic [SUM_W-1:0] sum;
  logic             priv_ok, allowed, cmp, prev_cmp, fire;

  always_comb begin
    sum = '0;
    for (int i = 0; i < NUM_LANES; i++) begin
      if (ev_valid[i] && ev_code[i*8 +: 8] == sel.evt &&
          (sel.umask == 8'h00 || (ev_unit[i*8 +: 8] & sel.umask) != 8'h00))
        sum = sum + SUM_W'(ev_cnt[i*CNT_W +: CNT_W]);
    end
  end

  generate
    if (CTR_IDX == 0) begin : g_rule0
      assign allowed = !(sel.evt >= 8'h11 && sel.evt <= 8'h13);
    end else begin : g_rule1
      assign allowed = (sel.evt != 8'hC1);
    end
  endgenerate

  assign priv_ok = priv_kernel ? sel.os : sel.usr;

  always_comb begin
    if (sel.cmask == 8'h00)
      cmp = priv_ok && (sum != '0);
    else if (sel.inv)
      cmp = priv_ok && (int'(sum) < int'(sel.cmask));
    else
      cmp = priv_ok && (int'(sum) >= int'(sel.cmask));
  end

  always_ff @(posedge clk) begin
    if (rst) prev_cmp <= 1'b0;
    else     prev_cmp <= cmp;
  end

  assign fire = sel.edg ? (cmp && !prev_cmp) : cmp;

  always_comb begin
    if (!global_en || !allowed)
      inc = '0;
    else if (sel.cmask == 8'h00 && !sel.edg)
      inc = priv_ok ? sum : '0;
    else
      inc = {{(SUM_W-1){1'b0}}, fire};
  end

  // R6: an edge-mode counter never adds on two consecutive cycles
  p_edge_single_r6: assert property (@(posedge clk) disable iff (rst)
    (sel.edg && sel.cmask != 8'h00 && inc != '0) |=> !(sel.edg && sel.cmask != 8'h00 && $stable(sel) && inc != '0));
endmodule

// File: rtl/pmu_counter.sv
module pmu_counter
  import pmu_pkg::*;
#(
  parameter int SUM_W = 6
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             sel_we,
  input  logic             cnt_we,
  input  logic [REG_W-1:0] wdata,
  input  logic [SUM_W-1:0] inc,
  output pmu_sel_t         sel_q,
  output logic [CTR_W-1:0] cnt_q,
  output logic             ovf
);
  logic [CTR_W:0] nxt;

  assign nxt = {1'b0, cnt_q} + (CTR_W+1)'(inc);
  assign ovf = !cnt_we && nxt[CTR_W];

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_q <= '0;
      cnt_q <= '0;
    end else begin
      if (sel_we) sel_q <= pmu_sel_t'(wdata & SEL_WMASK);
      if (cnt_we) cnt_q <= {{(CTR_W-REG_W){wdata[REG_W-1]}}, wdata};
      else        cnt_q <= nxt[CTR_W-1:0];
    end
  end

  p_sext_r9: assert property (@(posedge clk) disable iff (rst)
    cnt_we |=> cnt_q == {{(CTR_W-REG_W){$past(wdata[REG_W-1])}}, $past(wdata)});

  p_wrap_r11: assert property (@(posedge clk) disable iff (rst)
    ovf |=> cnt_q < (CTR_W)'(1 << SUM_W));
endmodule

// File: rtl/pmu_dual_ctr.sv
module pmu_dual_ctr
  import pmu_pkg::*;
#(
  parameter int NUM_LANES = 4,
  parameter int CNT_W     = 4,
  localparam int SUM_W    = $clog2(NUM_LANES * ((1 << CNT_W) - 1) + 1)
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       reg_we,
  input  logic [ADDR_W-1:0]          reg_addr,
  input  logic [REG_W-1:0]           reg_wdata,
  output logic [REG_W-1:0]           reg_rdata,
  input  logic [NUM_LANES-1:0]       ev_valid,
  input  logic [NUM_LANES*8-1:0]     ev_code,
  input  logic [NUM_LANES*8-1:0]     ev_unit,
  input  logic [NUM_LANES*CNT_W-1:0] ev_cnt,
  input  logic                       priv_kernel,
  output logic                       irq_o
);
  pmu_sel_t         sel_q [NCTR];
  logic [CTR_W-1:0] cnt_q [NCTR];
  logic [SUM_W-1:0] inc   [NCTR];
  logic [NCTR-1:0]  ovf, sel_we, cnt_we, int_hit;
  logic [NCTR-1:0]  ovf_flag;
  logic             irq_mask;
  logic             stat_we;

  assign stat_we = reg_we && reg_addr == ADDR_W'(STAT_IDX);

  generate
    for (genvar g = 0; g < NCTR; g++) begin : g_ctr
      assign sel_we[g]  = reg_we && reg_addr == ADDR_W'(g);
      assign cnt_we[g]  = reg_we && reg_addr == ADDR_W'(2 + 2*g);
      assign int_hit[g] = ovf[g] && sel_q[g].intr;

      pmu_evt_filter #(
        .CTR_IDX(g), .NUM_LANES(NUM_LANES), .CNT_W(CNT_W)
      ) u_filt (
        .clk(clk), .rst(rst), .sel(sel_q[g]), .global_en(sel_q[0].en),
        .ev_valid(ev_valid), .ev_code(ev_code), .ev_unit(ev_unit),
        .ev_cnt(ev_cnt), .priv_kernel(priv_kernel), .inc(inc[g])
      );

      pmu_counter #(.SUM_W(SUM_W)) u_cnt (
        .clk(clk), .rst(rst), .sel_we(sel_we[g]), .cnt_we(cnt_we[g]),
        .wdata(reg_wdata), .inc(inc[g]), .sel_q(sel_q[g]),
        .cnt_q(cnt_q[g]), .ovf(ovf[g])
      );

      always_ff @(posedge clk) begin
        if (rst)                                ovf_flag[g] <= 1'b0;
        else if (ovf[g])                        ovf_flag[g] <= 1'b1;
        else if (stat_we && reg_wdata[g])       ovf_flag[g] <= 1'b0;
      end

      p_stop_r8: assert property (@(posedge clk) disable iff (rst)
        (sel_q[g] == '0 && !cnt_we[g]) |=> $stable(cnt_q[g]));

      p_gate_r7: assert property (@(posedge clk) disable iff (rst)
        (!sel_q[0].en && !cnt_we[g]) |=> $stable(cnt_q[g]));

      p_rsv_zero_r2: assert property (@(posedge clk) disable iff (rst)
        !sel_q[g].rsv19 && !sel_q[g].rsv21);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      irq_o    <= 1'b0;
      irq_mask <= 1'b0;
    end else begin
      irq_o <= (|int_hit) && !irq_mask;
      if ((|int_hit) && !irq_mask)          irq_mask <= 1'b1;
      else if (stat_we && reg_wdata[NCTR])  irq_mask <= 1'b0;
    end
  end

  logic [REG_W-1:0] rd_mux;
  always_comb begin
    rd_mux = '0;
    if (reg_addr == ADDR_W'(STAT_IDX))
      rd_mux = REG_W'({irq_mask, ovf_flag});
    for (int c = 0; c < NCTR; c++) begin
      if (reg_addr == ADDR_W'(c))       rd_mux = REG_W'(sel_q[c]);
      if (reg_addr == ADDR_W'(2 + 2*c)) rd_mux = cnt_q[c][REG_W-1:0];
      if (reg_addr == ADDR_W'(3 + 2*c)) rd_mux = REG_W'(cnt_q[c][CTR_W-1:REG_W]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= rd_mux;
  end

  p_irq_pulse_r12: assert property (@(posedge clk) disable iff (rst)
    irq_o |=> !irq_o);

  p_irq_masks_r12: assert property (@(posedge clk) disable iff (rst)
    irq_o |-> irq_mask);
endmodule

// File: tb/pmu_dual_ctr_bench.sv
`timescale 1ns/1ps
module pmu_dual_ctr_bench;
  localparam int NL = 4;
  localparam int CW = 4;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [NL-1:0] ev_valid = '0;
  logic [NL*8-1:0] ev_code = '0;
  logic [NL*8-1:0] ev_unit = '0;
  logic [NL*CW-1:0] ev_cnt = '0;
  logic priv_kernel = 1'b0;
  logic irq_o;

  int n_chk = 0;
  int n_bad = 0;
  logic l1_on = 1'b0;
  logic [3:0] l1_cnt = '0;

  always #5 clk = ~clk;

  pmu_dual_ctr u_pmu_dual_ctr (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .ev_valid(ev_valid),
    .ev_code(ev_code), .ev_unit(ev_unit), .ev_cnt(ev_cnt),
    .priv_kernel(priv_kernel), .irq_o(irq_o)
  );

  typedef struct packed {
    logic [31:0] sel;
    logic [7:0]  code;
    logic [7:0]  unit;
    logic [3:0]  cnt;
    logic        kern;
    logic [15:0] exp;
  } vec_t;

  localparam int NV = 12;
  localparam vec_t VECS [NV] = '{
    '{32'h0041_0043, 8'h43, 8'h00, 4'd3, 1'b0, 16'd12}, // R3 basic sum
    '{32'h0041_0043, 8'h44, 8'h00, 4'd3, 1'b0, 16'd0},  // R3 code mismatch
    '{32'h0041_0043, 8'h43, 8'h00, 4'd3, 1'b1, 16'd0},  // R4 user only, kernel
    '{32'h0042_0043, 8'h43, 8'h00, 4'd2, 1'b1, 16'd8},  // R4 kernel only
    '{32'h0041_0F43, 8'h43, 8'h10, 4'd1, 1'b0, 16'd0},  // R3 umask miss
    '{32'h0041_0F43, 8'h43, 8'h02, 4'd1, 1'b0, 16'd4},  // R3 umask hit
    '{32'h0341_0043, 8'h43, 8'h00, 4'd5, 1'b0, 16'd4},  // R5 >= threshold
    '{32'h0641_0043, 8'h43, 8'h00, 4'd5, 1'b0, 16'd0},  // R5 below threshold
    '{32'h06C1_0043, 8'h43, 8'h00, 4'd5, 1'b0, 16'd4},  // R5 invert
    '{32'h0145_0043, 8'h43, 8'h00, 4'd2, 1'b0, 16'd1},  // R6 edge
    '{32'h0001_0043, 8'h43, 8'h00, 4'd3, 1'b0, 16'd0},  // R7 global enable off
    '{32'h0041_00C1, 8'hC1, 8'h00, 4'd1, 1'b0, 16'd4}   // R10 0xC1 on counter 0
  };
  string VTAG [NV] = '{"R3", "R3", "R4", "R4", "R3", "R3", "R5", "R5", "R5", "R6", "R7", "R10"};

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual 0x%08h expected 0x%08h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input logic [31:0] d);
    reg_we = 1'b1; reg_addr = 3'(a); reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input int a, output logic [31:0] d);
    reg_addr = 3'(a);
    @(negedge clk);
    d = reg_rdata;
  endtask

  task automatic lanes(input logic on, input logic [7:0] code, input logic [7:0] unit,
                       input logic [3:0] cnt);
    ev_valid = '0; ev_code = '0; ev_unit = '0; ev_cnt = '0;
    if (on) begin
      ev_valid[0] = 1'b1; ev_code[7:0] = code; ev_unit[7:0] = unit; ev_cnt[3:0] = cnt;
      if (l1_on) begin
        ev_valid[1] = 1'b1; ev_code[15:8] = code; ev_unit[15:8] = unit; ev_cnt[7:4] = l1_cnt;
      end
    end
  endtask

  // exactly four qualified cycles, then read counter ci bits 31:0
  task automatic window(input int ci, input logic [31:0] selv, input logic [7:0] code,
                        input logic [7:0] unit, input logic [3:0] cnt, input logic kern,
                        output logic [31:0] lo);
    wr(2 + 2*ci, 32'h0);
    wr(ci, selv);
    priv_kernel = kern;
    lanes(1'b1, code, unit, cnt);
    @(negedge clk); @(negedge clk); @(negedge clk);
    reg_we = 1'b1; reg_addr = 3'(ci); reg_wdata = 32'h0;
    @(negedge clk);
    reg_we = 1'b0;
    lanes(1'b0, 8'h0, 8'h0, 4'h0);
    priv_kernel = 1'b0;
    rd(2 + 2*ci, lo);
  endtask

  task automatic pulse43();
    lanes(1'b1, 8'h43, 8'h00, 4'd1);
    @(negedge clk);
    lanes(1'b0, 8'h0, 8'h0, 4'h0);
  endtask

  initial begin
    #2_000_000;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1 reset state
    for (int a = 0; a < 7; a++) begin
      rd(a, v);
      chk($sformatf("R1 reset reg %0d", a), v, 32'h0);
    end
    chk("R1 reset irq", {31'h0, irq_o}, 32'h0);

    // vector table on counter 0
    for (int i = 0; i < NV; i++) begin
      window(0, VECS[i].sel, VECS[i].code, VECS[i].unit, VECS[i].cnt, VECS[i].kern, v);
      chk($sformatf("%s vector %0d", VTAG[i], i), v, 32'(VECS[i].exp));
    end

    // R3 two matching lanes summed
    l1_on = 1'b1; l1_cnt = 4'd4;
    window(0, 32'h0041_0043, 8'h43, 8'h00, 4'd3, 1'b0, v);
    chk("R3 two lanes", v, 32'd28);
    l1_on = 1'b0;

    // R7 / R10 counter 1
    wr(0, 32'h0040_0000);
    window(1, 32'h0001_0011, 8'h11, 8'h00, 4'd1, 1'b0, v);
    chk("R7 counter 1 enabled by select 0", v, 32'd4);
    window(1, 32'h0001_00C1, 8'hC1, 8'h00, 4'd1, 1'b0, v);
    chk("R10 0xC1 on counter 1", v, 32'd0);
    wr(0, 32'h0);
    window(1, 32'h0041_0011, 8'h11, 8'h00, 4'd1, 1'b0, v);
    chk("R7 select 1 enable bit ignored", v, 32'd0);
    window(0, 32'h0041_0012, 8'h12, 8'h00, 4'd1, 1'b0, v);
    chk("R10 0x12 on counter 0", v, 32'd0);

    // R8 zero select stops
    wr(2, 32'd9);
    wr(0, 32'h0);
    lanes(1'b1, 8'h00, 8'h00, 4'd3);
    repeat (3) @(negedge clk);
    lanes(1'b0, 8'h0, 8'h0, 4'h0);
    rd(2, v);
    chk("R8 zero select holds", v, 32'd9);

    // R9 sign extension and ignored high writes
    wr(4, 32'h8000_0000);
    rd(4, v); chk("R9 low word", v, 32'h8000_0000);
    rd(5, v); chk("R9 high byte", v, 32'h0000_00FF);
    wr(5, 32'h0000_0012);
    rd(5, v); chk("R9 high write ignored", v, 32'h0000_00FF);
    wr(2, 32'h7FFF_FFFF);
    rd(3, v); chk("R9 positive high byte", v, 32'h0);

    // R2 reserved bits
    wr(0, 32'hFFFF_FFFF);
    rd(0, v); chk("R2 reserved bits zero", v, 32'hFFD7_FFFF);
    wr(0, 32'h0);
    wr(6, 32'h7);

    // R11 / R12 overflow and interrupt
    wr(0, 32'h0051_0043);
    wr(2, 32'hFFFF_FFFF);
    pulse43();
    chk("R12 irq raised", {31'h0, irq_o}, 32'h1);
    @(negedge clk);
    chk("R12 irq one cycle", {31'h0, irq_o}, 32'h0);
    rd(2, v); chk("R11 wrap low", v, 32'h0);
    rd(3, v); chk("R11 wrap high", v, 32'h0);
    rd(6, v); chk("R11 sticky flag and R12 mask", v, 32'h5);
    wr(2, 32'hFFFF_FFFF);
    pulse43();
    chk("R12 masked no irq", {31'h0, irq_o}, 32'h0);
    wr(6, 32'h7);
    rd(6, v); chk("R11 flag cleared", v, 32'h0);
    wr(2, 32'hFFFF_FFFF);
    pulse43();
    chk("R12 irq after unmask", {31'h0, irq_o}, 32'h1);
    wr(0, 32'h0);
    wr(6, 32'h7);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule